// File: doc/BRIEF.md
# Two-Stage Protected Watchdog Timer

This block is a watchdog with two countdown stages in a row. Once it is enabled, the first stage counts down from its preset value. When it expires it sets an interrupt flag, which can also drive an interrupt line. The second stage then counts down from its own preset. When it expires, the block sets a sticky timeout flag and asserts a reset request. Software stops this from happening by reloading both stages before the first stage runs out.

The preset registers and the reload register are protected. A write to any of them takes effect only right after a two-word magic key has been written to the reload offset, and each key opens exactly one such write. A configuration register selects the tick rate, the interrupt type and whether the reset output is used. A control register holds the enable bit, the mode bit and a lock bit. Once the lock bit is set, the configuration and control registers are frozen until the next reset. The timeout flag survives the reset that the watchdog itself requests (`sys_rst_i`) and is cleared only by power-on reset (`rst_ni`) or by an explicit clear.

Top module: `wdt_two_stage`

## Requirements
- R1: Writing 0x00000080 and then 0x00000086 to offset 0x0C opens exactly one write to a protected offset (0x00 stage-1 preset, 0x04 stage-2 preset, 0x0C reload), and that write takes effect.
- R2: After the one permitted protected write the registers relock, and a further protected write without a new key sequence is ignored.
- R3: A protected write without a completed key sequence is ignored. After 0x80, any write other than 0x86 to 0x0C (a different value, or a write to any other offset) aborts the sequence, and a later 0x86 does not open the registers.
- R4: Reads: 0x00 and 0x04 return the presets (reset value all ones); 0x08 bit 0 is the interrupt flag; 0x0C bit 9 is the timeout flag; 0x10 returns the configuration (bit 5 reset disable, bit 2 fast tick, bits 1:0 interrupt type); 0x14 returns the control bits (bit 2 timer mode, bit 1 enable, bit 0 lock). All of these reset to 0.
- R5: A protected write to 0x0C with bit 8 set reloads both stages from their presets and restarts the tick divider.
- R6: Stage 1 expires on the (P1+1)-th tick after enable or reload and sets the interrupt flag. `irq_o` follows that flag unless the interrupt type is 11. Writing 1 to bit 0 of 0x08 clears the flag.
- R7: In watchdog mode, stage 2 expires P2+1 ticks after stage 1 and sets the timeout flag and `wdt_rst_o`. A protected write of bit 9 at 0x0C clears the timeout flag.
- R8: A tick occurs every 2^SLOW_LOG2 clocks when config bit 2 is 0, and every 2^FAST_LOG2 clocks when it is 1.
- R9: With control bit 2 set (timer mode), stage 1 reloads itself on each expiry and sets the interrupt flag every P1+1 ticks. Stage 2 never runs, so no timeout or reset occurs.
- R10: While the lock bit is set, writes to 0x10 and 0x14 are ignored. The lock is cleared only by `sys_rst_i` or `rst_ni`.
- R11: `sys_rst_i` returns every register except the timeout flag to its reset value. Only `rst_ni` clears the timeout flag.
- R12: While the enable bit is clear, both stages hold their presets, so the next enable starts a full count, and `irq_o` and `wdt_rst_o` stay low.
- R13: With config bit 5 set, stage-2 expiry still sets the timeout flag but `wdt_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_i | input | 1 | Synchronous system reset, active high, keeps the timeout flag |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_o | output | 1 | Stage-1 interrupt |
| wdt_rst_o | output | 1 | Reset request after stage-2 expiry |

## Verification
On every cycle, the assertions check the following:
- Two protected writes are never granted back to back.
- A preset changes only when a write has been granted.
- The lock bit, and the enable bit while locked, stay fixed.
- Each expiry sets its flag.
- The timeout flag survives a system reset.
- A disabled counter holds its preset.

Some behaviours can only be shown by the bench scenarios:
- The exact expiry cycles at both tick rates.
- The effect of aborted key sequences.
- Masking by interrupt type 11 and by the reset-disable bit.
- Timer-mode repetition.
- A full recount after a disable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OFF_PRE1 = 5'h00;
  localparam addr_t OFF_PRE2 = 5'h04;
  localparam addr_t OFF_ISR  = 5'h08;
  localparam addr_t OFF_RLD  = 5'h0C;
  localparam addr_t OFF_CFG  = 5'h10;
  localparam addr_t OFF_CTL  = 5'h14;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

  localparam int RLD_BIT   = 8;
  localparam int TMO_BIT   = 9;
  localparam int CFG_FAST  = 2;
  localparam int CFG_NORST = 5;
  localparam int CTL_LOCK  = 0;
  localparam int CTL_EN    = 1;
  localparam int CTL_TMR   = 2;

  typedef enum logic [1:0] {UNL_IDLE, UNL_ARMED, UNL_OPEN} unl_e;
  typedef enum logic [1:0] {STG_ONE, STG_TWO, STG_DONE} stg_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic fast_i,
  output logic tick_o
);
  logic [SLOW_LOG2-1:0] pre_q;
  logic fast_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (!run_i || clr_i) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  generate
    if (FAST_LOG2 == 0) begin : g_fast_every
      assign fast_hit = 1'b1;
    end else begin : g_fast_div
      assign fast_hit = &pre_q[FAST_LOG2-1:0];
    end
  endgenerate

  assign tick_o = run_i & (fast_i ? fast_hit : &pre_q);
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  addr_t         addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          grant_o
);
  unl_e st_q, st_d;
  logic is_rld, is_prot;

  assign is_rld  = addr_i == OFF_RLD;
  assign is_prot = is_rld || addr_i == OFF_PRE1 || addr_i == OFF_PRE2;

  always_comb begin
    st_d    = st_q;
    grant_o = 1'b0;
    if (we_i && !clr_i) begin
      unique case (st_q)
        UNL_IDLE:  if (is_rld && wdata_i == DW'(KEY_FIRST)) st_d = UNL_ARMED;
        UNL_ARMED: st_d = (is_rld && wdata_i == DW'(KEY_SECOND)) ? UNL_OPEN : UNL_IDLE;
        UNL_OPEN:  if (is_prot) begin
          grant_o = 1'b1;
          st_d    = UNL_IDLE;
        end
        default:   st_d = UNL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= UNL_IDLE;
    else if (clr_i) st_q <= UNL_IDLE;
    else st_q <= st_d;
  end
endmodule

// File: rtl/wdt_stages.sv
module wdt_stages
  import wdt_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          reload_i,
  input  logic          timer_mode_i,
  input  logic          tick_i,
  input  logic [CW-1:0] pre1_i,
  input  logic [CW-1:0] pre2_i,
  output logic          exp1_o,
  output logic          exp2_o,
  output logic [CW-1:0] cnt1_o,
  output logic [CW-1:0] cnt2_o
);
  stg_e st_q;
  logic [CW-1:0] cnt1_q, cnt2_q;
  logic step;

  assign step   = run_i & ~reload_i & tick_i;
  assign exp1_o = step && st_q == STG_ONE && cnt1_q == '0;
  assign exp2_o = step && st_q == STG_TWO && cnt2_q == '0;
  assign cnt1_o = cnt1_q;
  assign cnt2_o = cnt2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= STG_ONE;
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else if (!run_i || reload_i) begin
      st_q   <= STG_ONE;
      cnt1_q <= pre1_i;
      cnt2_q <= pre2_i;
    end else if (tick_i) begin
      unique case (st_q)
        STG_ONE: begin
          if (cnt1_q != '0) cnt1_q <= cnt1_q - 1'b1;
          else if (timer_mode_i) cnt1_q <= pre1_i;
          else st_q <= STG_TWO;
        end
        STG_TWO: begin
          if (cnt2_q != '0) cnt2_q <= cnt2_q - 1'b1;
          else st_q <= STG_DONE;
        end
        default: st_q <= STG_DONE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DW        = 32,
  parameter int CW        = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic [CW-1:0] pre1_q, pre2_q, cnt1, cnt2;
  logic [1:0] itype_q;
  logic fast_q, norst_q;
  logic lck_en_q, lck_tmr_q, lck_lock_q;
  logic int_q, tmo_q, fired_q;
  logic grant, tick, exp1, exp2;
  logic reload_hit, tmo_clr, isr_clr, cfg_wr, ctl_wr;

  wdt_unlock #(.DW(DW)) u_unl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sys_rst_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .grant_o(grant)
  );

  assign reload_hit = grant && addr_i == OFF_RLD && wdata_i[RLD_BIT];
  assign tmo_clr    = grant && addr_i == OFF_RLD && wdata_i[TMO_BIT];
  assign isr_clr    = we_i && addr_i == OFF_ISR && wdata_i[0];
  assign cfg_wr     = we_i && addr_i == OFF_CFG && !lck_lock_q;
  assign ctl_wr     = we_i && addr_i == OFF_CTL && !lck_lock_q;

  wdt_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(lck_en_q), .clr_i(reload_hit),
    .fast_i(fast_q), .tick_o(tick)
  );

  wdt_stages #(.CW(CW)) u_stg (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(lck_en_q), .reload_i(reload_hit),
    .timer_mode_i(lck_tmr_q), .tick_i(tick), .pre1_i(pre1_q), .pre2_i(pre2_q),
    .exp1_o(exp1), .exp2_o(exp2), .cnt1_o(cnt1), .cnt2_o(cnt2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre1_q <= '1; pre2_q <= '1;
      itype_q <= '0; fast_q <= 1'b0; norst_q <= 1'b0;
      lck_en_q <= 1'b0; lck_tmr_q <= 1'b0; lck_lock_q <= 1'b0;
      int_q <= 1'b0; fired_q <= 1'b0;
    end else if (sys_rst_i) begin
      pre1_q <= '1; pre2_q <= '1;
      itype_q <= '0; fast_q <= 1'b0; norst_q <= 1'b0;
      lck_en_q <= 1'b0; lck_tmr_q <= 1'b0; lck_lock_q <= 1'b0;
      int_q <= 1'b0; fired_q <= 1'b0;
    end else begin
      if (grant && addr_i == OFF_PRE1) pre1_q <= wdata_i[CW-1:0];
      if (grant && addr_i == OFF_PRE2) pre2_q <= wdata_i[CW-1:0];
      if (cfg_wr) begin
        itype_q <= wdata_i[1:0];
        fast_q  <= wdata_i[CFG_FAST];
        norst_q <= wdata_i[CFG_NORST];
      end
      if (ctl_wr) begin
        lck_en_q   <= wdata_i[CTL_EN];
        lck_tmr_q  <= wdata_i[CTL_TMR];
        lck_lock_q <= wdata_i[CTL_LOCK];
      end
      if (exp1) int_q <= 1'b1;
      else if (isr_clr) int_q <= 1'b0;
      if (!lck_en_q || reload_hit) fired_q <= 1'b0;
      else if (exp2) fired_q <= 1'b1;
    end
  end

  // timeout flag: only power-on reset or explicit clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= 1'b0;
    else if (exp2) tmo_q <= 1'b1;
    else if (tmo_clr && !sys_rst_i) tmo_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_PRE1: rdata_o = DW'(pre1_q);
      OFF_PRE2: rdata_o = DW'(pre2_q);
      OFF_ISR:  rdata_o[0] = int_q;
      OFF_RLD:  rdata_o[TMO_BIT] = tmo_q;
      OFF_CFG:  begin
        rdata_o[1:0]       = itype_q;
        rdata_o[CFG_FAST]  = fast_q;
        rdata_o[CFG_NORST] = norst_q;
      end
      OFF_CTL:  begin
        rdata_o[CTL_LOCK] = lck_lock_q;
        rdata_o[CTL_EN]   = lck_en_q;
        rdata_o[CTL_TMR]  = lck_tmr_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = int_q & lck_en_q & (itype_q != 2'b11);
  assign wdt_rst_o = fired_q & lck_en_q & ~norst_q;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sys_rst_i,
  input logic          grant,
  input logic [CW-1:0] pre1_q,
  input logic [CW-1:0] pre2_q,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cnt2,
  input logic          lck_en_q,
  input logic          lck_lock_q,
  input logic          int_q,
  input logic          tmo_q,
  input logic          exp1,
  input logic          exp2
);
  // R2: one key sequence opens a single write
  a_r2_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> !grant);

  // R1, R3: presets change only through a granted write
  a_r3_preset_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre1_q != $past(pre1_q)) && !$past(sys_rst_i) |-> $past(grant));

  a_r10_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lck_lock_q && !sys_rst_i |=> lck_lock_q);

  a_r10_en_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lck_lock_q && !sys_rst_i |=> $stable(lck_en_q));

  a_r6_int_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp1 && !sys_rst_i |=> int_q);

  a_r7_tmo_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp2 |=> tmo_q);

  a_r11_tmo_survives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q && sys_rst_i |=> tmo_q);

  a_r12_hold_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lck_en_q |=> cnt1 == $past(pre1_q) && cnt2 == $past(pre2_q));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .grant(grant),
  .pre1_q(pre1_q), .pre2_q(pre2_q), .cnt1(cnt1), .cnt2(cnt2),
  .lck_en_q(lck_en_q), .lck_lock_q(lck_lock_q), .int_q(int_q),
  .tmo_q(tmo_q), .exp1(exp1), .exp2(exp2)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam int CW = 8;
  localparam int SLOW = 4;
  localparam int FAST = 2;
  localparam int DS = 1 << SLOW;
  localparam int DF = 1 << FAST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, wrst;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wdt_two_stage #(.DW(32), .CW(CW), .SLOW_LOG2(SLOW), .FAST_LOG2(FAST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic unl();
    wr(5'h0C, 32'h80);
    wr(5'h0C, 32'h86);
  endtask

  task automatic pwr(input logic [4:0] a, input logic [31:0] d);
    unl();
    wr(a, d);
  endtask

  task automatic sysrst();
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
  endtask

  // expects irq low after edge n-1 and high after edge n, counted from the last commit
  task automatic irq_at(input int n, input string tag);
    step(n - 1);
    chk(tag, {31'b0, irq}, 32'd0);
    step(1);
    chk(tag, {31'b0, irq}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R4 reset state
    rdchk("R4 pre1 reset", 5'h00, 32'hFF);
    rdchk("R4 pre2 reset", 5'h04, 32'hFF);
    rdchk("R4 isr reset", 5'h08, 32'h0);
    rdchk("R4 rld reset", 5'h0C, 32'h0);
    rdchk("R4 cfg reset", 5'h10, 32'h0);
    rdchk("R4 ctl reset", 5'h14, 32'h0);
    chk("R4 irq reset", {31'b0, irq}, 0);
    chk("R4 rst reset", {31'b0, wrst}, 0);

    // R3 locked write ignored
    wr(5'h00, 32'h3);
    rdchk("R3 locked write", 5'h00, 32'hFF);
    // R1 unlock opens a write
    pwr(5'h00, 32'h3);
    rdchk("R1 unlocked write", 5'h00, 32'h3);
    // R2 relocked afterwards
    wr(5'h00, 32'h5);
    rdchk("R2 second write", 5'h00, 32'h3);
    // R3 wrong second key aborts
    wr(5'h0C, 32'h80); wr(5'h0C, 32'h55); wr(5'h0C, 32'h86); wr(5'h00, 32'h9);
    rdchk("R3 wrong key", 5'h00, 32'h3);
    // R3 other offset aborts
    wr(5'h0C, 32'h80); wr(5'h04, 32'h7); wr(5'h04, 32'h7);
    rdchk("R3 other offset", 5'h04, 32'hFF);
    pwr(5'h04, 32'h2);
    rdchk("R1 pre2 write", 5'h04, 32'h2);
    wr(5'h10, 32'h04);
    rdchk("R4 cfg readback", 5'h10, 32'h04);

    // R6/R7 full expiry with fast tick, P1=3 P2=2
    wr(5'h14, 32'h2);
    irq_at((3 + 1) * DF, "R6 stage1 expiry");
    rdchk("R6 isr flag", 5'h08, 32'h1);
    step((2 + 1) * DF - 1);
    chk("R7 before stage2", {31'b0, wrst}, 0);
    rdchk("R7 tmo not yet", 5'h0C, 32'h0);
    step(1);
    chk("R7 stage2 expiry", {31'b0, wrst}, 1);
    rdchk("R7 tmo flag", 5'h0C, 32'h200);

    // R11 system reset keeps timeout flag
    sysrst();
    rdchk("R11 tmo kept", 5'h0C, 32'h200);
    rdchk("R11 ctl cleared", 5'h14, 32'h0);
    rdchk("R11 pre1 cleared", 5'h00, 32'hFF);
    chk("R11 rst dropped", {31'b0, wrst}, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rdchk("R11 por clears tmo", 5'h0C, 32'h0);

    // R5 reload restarts count
    pwr(5'h00, 32'h3); pwr(5'h04, 32'h2); wr(5'h10, 32'h04);
    wr(5'h14, 32'h2);
    step(4);
    pwr(5'h0C, 32'h100);
    irq_at((3 + 1) * DF, "R5 reload restart");
    wr(5'h08, 32'h1);
    rdchk("R6 isr clear", 5'h08, 32'h0);
    chk("R6 irq after clear", {31'b0, irq}, 0);
    wr(5'h10, 32'h24);
    step(7);
    rdchk("R13 tmo not yet", 5'h0C, 32'h0);
    step(1);
    chk("R13 rst masked", {31'b0, wrst}, 0);
    rdchk("R13 tmo still set", 5'h0C, 32'h200);
    pwr(5'h0C, 32'h200);
    rdchk("R7 tmo clear", 5'h0C, 32'h0);

    // R12 disable holds presets
    wr(5'h14, 32'h0); wr(5'h10, 32'h04); wr(5'h08, 32'h1);
    wr(5'h14, 32'h2);
    step(10);
    wr(5'h14, 32'h0);
    step(100);
    chk("R12 no irq disabled", {31'b0, irq}, 0);
    chk("R12 no rst disabled", {31'b0, wrst}, 0);
    wr(5'h14, 32'h2);
    irq_at((3 + 1) * DF, "R12 full count after enable");
    step((2 + 1) * DF);
    chk("R12 rst before disable", {31'b0, wrst}, 1);
    wr(5'h14, 32'h0);
    chk("R12 rst off when disabled", {31'b0, wrst}, 0);
    chk("R12 irq off when disabled", {31'b0, irq}, 0);
    pwr(5'h0C, 32'h200); wr(5'h08, 32'h1);

    // R9 timer mode repeats stage 1
    wr(5'h14, 32'h6);
    irq_at((3 + 1) * DF, "R9 first period");
    wr(5'h08, 32'h1);
    irq_at((3 + 1) * DF - 2, "R9 second period");
    step(100);
    chk("R9 no reset", {31'b0, wrst}, 0);
    rdchk("R9 no timeout", 5'h0C, 32'h0);
    wr(5'h14, 32'h0);

    // R8 slow tick
    wr(5'h08, 32'h1); wr(5'h10, 32'h00);
    wr(5'h14, 32'h2);
    irq_at((3 + 1) * DS, "R8 slow tick");
    wr(5'h14, 32'h0);

    // R6 interrupt type 11 masks irq
    wr(5'h08, 32'h1); wr(5'h10, 32'h07);
    wr(5'h14, 32'h2);
    step((3 + 1) * DF);
    chk("R6 type11 masked", {31'b0, irq}, 0);
    rdchk("R6 type11 flag", 5'h08, 32'h1);
    wr(5'h14, 32'h0);

    // R10 lock freezes config and control
    wr(5'h08, 32'h1); wr(5'h10, 32'h04);
    wr(5'h14, 32'h3);
    wr(5'h14, 32'h0);
    wr(5'h10, 32'h27);
    rdchk("R10 ctl frozen", 5'h14, 32'h3);
    rdchk("R10 cfg frozen", 5'h10, 32'h04);
    step((3 + 1) * DF - 4 - 1);
    chk("R10 still running", {31'b0, irq}, 0);
    step(1);
    chk("R10 still running", {31'b0, irq}, 1);
    sysrst();
    rdchk("R10 lock cleared by reset", 5'h14, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule